// File: doc/BRIEF.md
# Vector Scalar Load-Store Unit

This unit moves a scalar-sized chunk of 1, 2, 4 or 8 bytes between a byte-addressed data memory and one 128-bit vector register. It decodes a 32-bit coprocessor memory instruction and reads the base address from a scalar register read port. It then forms a byte address that may be unaligned and may wrap past the top of memory.

A load places consecutive memory bytes into a window of the vector register that starts at a chosen byte index. Only the bytes in that window are written. A store sends register bytes to memory.

Near the end of the register the two directions behave differently. A load stops at byte 15 and writes fewer bytes. A store wraps its byte index back to 0 and always writes the full size.

The unit is a short pipeline:
- Cycle 0: an instruction is presented with its valid strobe.
- Cycle 1: the memory request is issued. A store writes memory in this cycle. A load issues its read, which the memory answers one cycle later from a register.
- Cycle 2: a load writes the returned bytes back into the vector register file.

A store in its request cycle sees any bytes that a load is writing back to the same vector register in that same cycle.

Top module: `vsls_unit`

## Requirements
- R1: The byte address is the 32-bit scalar base value plus the 7-bit two's-complement offset (`instr_i[6:0]`), sign-extended and multiplied by the access size. Only the low 12 bits are kept. Memory lane k addresses (address + k) mod 4096, so an access that crosses the top of memory continues at 0.
- R2: `instr_i[31:26]` = 6'h32 selects a load and 6'h3A selects a store. `instr_i[15:11]` values 0, 1, 2 and 3 give sizes of 1, 2, 4 and 8 bytes. `instr_i[25:21]` selects the scalar base register, `instr_i[20:16]` selects the vector register and `instr_i[10:7]` is the starting byte index e.
- R3: A load writes vector bytes e .. e+size-1 and leaves every other byte of the register unchanged. Vector byte e+k receives memory lane k.
- R4: A load whose window runs past byte 15 writes only bytes e..15, taking them from the first 16-e memory lanes.
- R5: A store always writes exactly size bytes to memory. Memory lane k receives vector byte (e+k) mod 16.
- R6: Vector byte i occupies bits [127-8i -: 8], so each 16-bit lane n is big-endian and holds bytes 2n and 2n+1. Memory lane k uses address bits [12k +: 12] and data bits [8k +: 8].
- R7: A load or store major opcode with a size code of 4 to 31 makes no memory access and no register write. It raises `unsup_o` for the single cycle after the valid strobe.
- R8: The memory request appears in the cycle after the valid strobe. A store writes memory in that cycle. A load's write-back strobe comes one cycle after its read request.
- R9: A store whose request cycle coincides with a load write-back to the same vector register uses the newly loaded bytes in place of the stale register contents.
- R10: While `rst_ni` is low, no memory request, register write or unsupported flag is raised.
- R11: An instruction with any other major opcode is ignored silently, with no access and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| base_idx_o | output | 5 | Scalar register index for the base address |
| base_val_i | input | 32 | Scalar register value (combinational reply to base_idx_o) |
| vreg_ridx_o | output | 5 | Vector register read index (store data) |
| vreg_rdata_i | input | 128 | Vector register read data (combinational reply) |
| vreg_we_o | output | 1 | Vector register write strobe |
| vreg_widx_o | output | 5 | Vector register write index |
| vreg_wbe_o | output | 16 | Per-byte write enables, bit i enables vector byte i |
| vreg_wdata_o | output | 128 | Vector register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_lane_en_o | output | 8 | Per-lane enables |
| mem_addr_o | output | 96 | Eight 12-bit lane byte addresses |
| mem_wdata_o | output | 64 | Eight lane write bytes |
| mem_rdata_i | input | 64 | Eight lane read bytes, registered one cycle after the request |
| unsup_o | output | 1 | Unsupported size code seen |

## Verification
A load's write-back to a vector register can fall in the same cycle as the register read of a store issued one cycle later. The test provokes this by issuing an 8-byte load into one vector register and, in the very next cycle, an 8-byte store from that same register to another address. The bytes the store leaves in memory are compared with a sequential model in which the load has already completed. The test also sets scalar base values with non-zero upper bits and uses windows that cross the top of memory and the end of the register. This exercises address truncation and both wrapping behaviours against a byte-level model.

// File: rtl/vsls_pkg.sv
package vsls_pkg;
  localparam int EL_W   = 4;
  localparam int VBYTES = 1 << EL_W;
  localparam int VW     = 8 * VBYTES;
  localparam int MAXB   = 8;
  localparam int OFF_W  = 7;
  localparam int SUB_W  = 5;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OPC_LOAD  = 6'h32;
  localparam logic [5:0] OPC_STORE = 6'h3A;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_BAD   = 2'd3
  } kind_e;
endpackage

// File: rtl/vsls_decode.sv
module vsls_decode
  import vsls_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 12
) (
  input  logic              instr_valid_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   base_val_i,
  output logic [RIDX_W-1:0] base_idx_o,
  output kind_e             kind_o,
  output logic [1:0]        sz_o,
  output logic [EL_W-1:0]   elem_o,
  output logic [RIDX_W-1:0] vt_o,
  output logic [AW-1:0]     addr_o
);
  logic [5:0]       major;
  logic [SUB_W-1:0] sub;
  logic [XLEN-1:0]  off_ext;
  logic [XLEN-1:0]  scaled;
  logic [XLEN-1:0]  sum;
  logic             unused_sum_hi;

  assign major      = instr_i[31:26];
  assign sub        = instr_i[15:11];
  assign base_idx_o = instr_i[25:21];
  assign vt_o       = instr_i[20:16];
  assign elem_o     = instr_i[7 +: EL_W];
  assign sz_o       = sub[1:0];

  // signed offset scaled by access size
  assign off_ext = {{(XLEN-OFF_W){instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0]};
  assign scaled  = off_ext << sub[1:0];
  assign sum     = base_val_i + scaled;
  assign addr_o  = sum[AW-1:0];
  assign unused_sum_hi = ^{sum[XLEN-1:AW], instr_i[10:7+EL_W]};

  always_comb begin
    kind_o = K_NONE;
    if (instr_valid_i && (major == OPC_LOAD || major == OPC_STORE)) begin
      if (sub < SUB_W'(4)) kind_o = (major == OPC_LOAD) ? K_LOAD : K_STORE;
      else                 kind_o = K_BAD;
    end
  end
endmodule

// File: rtl/vsls_req_stage.sv
module vsls_req_stage
  import vsls_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  kind_e             kind_i,
  input  logic [1:0]        sz_i,
  input  logic [EL_W-1:0]   elem_i,
  input  logic [RIDX_W-1:0] vt_i,
  input  logic [AW-1:0]     addr_i,
  output logic [RIDX_W-1:0] vreg_ridx_o,
  input  logic [VW-1:0]     vreg_rdata_i,
  input  logic              fwd_we_i,
  input  logic [RIDX_W-1:0] fwd_idx_i,
  input  logic [VBYTES-1:0] fwd_be_i,
  input  logic [VW-1:0]     fwd_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MAXB-1:0]   mem_lane_en_o,
  output logic [MAXB*AW-1:0] mem_addr_o,
  output logic [MAXB*8-1:0] mem_wdata_o,
  output logic              unsup_o,
  output logic              ld_go_o,
  output logic [1:0]        ld_sz_o,
  output logic [EL_W-1:0]   ld_elem_o,
  output logic [RIDX_W-1:0] ld_vt_o
);
  logic              valid_q, store_q, unsup_q;
  logic [1:0]        sz_q;
  logic [EL_W-1:0]   elem_q;
  logic [RIDX_W-1:0] vt_q;
  logic [AW-1:0]     addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      store_q <= 1'b0;
      unsup_q <= 1'b0;
      sz_q    <= '0;
      elem_q  <= '0;
      vt_q    <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= (kind_i == K_LOAD) || (kind_i == K_STORE);
      store_q <= (kind_i == K_STORE);
      unsup_q <= (kind_i == K_BAD);
      sz_q    <= sz_i;
      elem_q  <= elem_i;
      vt_q    <= vt_i;
      addr_q  <= addr_i;
    end
  end

  assign vreg_ridx_o = vt_q;
  assign mem_req_o   = valid_q;
  assign mem_we_o    = valid_q & store_q;
  assign unsup_o     = unsup_q;
  assign ld_go_o     = valid_q & ~store_q;
  assign ld_sz_o     = sz_q;
  assign ld_elem_o   = elem_q;
  assign ld_vt_o     = vt_q;

  // consecutive lane addresses, wrapping at the memory size
  for (genvar k = 0; k < MAXB; k++) begin : g_lane_addr
    assign mem_addr_o[k*AW +: AW] = addr_q + AW'(k);
  end

  // merge write-back bytes landing in the same cycle
  logic [7:0] merged [VBYTES];
  logic       fwd_hit;
  assign fwd_hit = fwd_we_i && (fwd_idx_i == vt_q);

  always_comb begin
    for (int i = 0; i < VBYTES; i++) begin
      merged[i] = (fwd_hit && fwd_be_i[i]) ? fwd_data_i[VW-1-8*i -: 8]
                                           : vreg_rdata_i[VW-1-8*i -: 8];
    end
  end

  int              nb;
  logic [EL_W-1:0] src_idx;

  always_comb begin
    nb            = 1 << sz_q;
    mem_lane_en_o = '0;
    mem_wdata_o   = '0;
    src_idx       = '0;
    for (int k = 0; k < MAXB; k++) begin
      src_idx = elem_q + EL_W'(k);  // wraps within the register
      if (k < nb) begin
        mem_lane_en_o[k] = valid_q;
        if (valid_q && store_q) mem_wdata_o[8*k +: 8] = merged[src_idx];
      end
    end
  end
endmodule

// File: rtl/vsls_wb_stage.sv
module vsls_wb_stage
  import vsls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_go_i,
  input  logic [1:0]        sz_i,
  input  logic [EL_W-1:0]   elem_i,
  input  logic [RIDX_W-1:0] vt_i,
  input  logic [MAXB*8-1:0] mem_rdata_i,
  output logic              vreg_we_o,
  output logic [RIDX_W-1:0] vreg_widx_o,
  output logic [VBYTES-1:0] vreg_wbe_o,
  output logic [VW-1:0]     vreg_wdata_o
);
  logic              go_q;
  logic [1:0]        sz_q;
  logic [EL_W-1:0]   elem_q;
  logic [RIDX_W-1:0] vt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      sz_q   <= '0;
      elem_q <= '0;
      vt_q   <= '0;
    end else begin
      go_q   <= ld_go_i;
      sz_q   <= sz_i;
      elem_q <= elem_i;
      vt_q   <= vt_i;
    end
  end

  assign vreg_we_o   = go_q;
  assign vreg_widx_o = vt_q;

  int nb;

  // byte i takes lane k when elem+k == i; no wrap, so the window truncates
  always_comb begin
    nb           = 1 << sz_q;
    vreg_wbe_o   = '0;
    vreg_wdata_o = '0;
    for (int i = 0; i < VBYTES; i++) begin
      for (int k = 0; k < MAXB; k++) begin
        if (k < nb && ({1'b0, elem_q} + (EL_W+1)'(k)) == (EL_W+1)'(i)) begin
          vreg_wbe_o[i]                 = go_q;
          vreg_wdata_o[VW-1-8*i -: 8]   = mem_rdata_i[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/vsls_unit.sv
module vsls_unit
  import vsls_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int MEM_AW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  instr_valid_i,
  input  logic [31:0]           instr_i,
  output logic [4:0]            base_idx_o,
  input  logic [XLEN-1:0]       base_val_i,
  output logic [4:0]            vreg_ridx_o,
  input  logic [127:0]          vreg_rdata_i,
  output logic                  vreg_we_o,
  output logic [4:0]            vreg_widx_o,
  output logic [15:0]           vreg_wbe_o,
  output logic [127:0]          vreg_wdata_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [7:0]            mem_lane_en_o,
  output logic [8*MEM_AW-1:0]   mem_addr_o,
  output logic [63:0]           mem_wdata_o,
  input  logic [63:0]           mem_rdata_i,
  output logic                  unsup_o
);
  kind_e             dec_kind;
  logic [1:0]        dec_sz;
  logic [EL_W-1:0]   dec_elem;
  logic [RIDX_W-1:0] dec_vt;
  logic [MEM_AW-1:0] dec_addr;

  logic              ld_go;
  logic [1:0]        ld_sz;
  logic [EL_W-1:0]   ld_elem;
  logic [RIDX_W-1:0] ld_vt;

  vsls_decode #(.XLEN(XLEN), .AW(MEM_AW)) u_dec (
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .base_val_i    (base_val_i),
    .base_idx_o    (base_idx_o),
    .kind_o        (dec_kind),
    .sz_o          (dec_sz),
    .elem_o        (dec_elem),
    .vt_o          (dec_vt),
    .addr_o        (dec_addr)
  );

  vsls_req_stage #(.AW(MEM_AW)) u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .kind_i        (dec_kind),
    .sz_i          (dec_sz),
    .elem_i        (dec_elem),
    .vt_i          (dec_vt),
    .addr_i        (dec_addr),
    .vreg_ridx_o   (vreg_ridx_o),
    .vreg_rdata_i  (vreg_rdata_i),
    .fwd_we_i      (vreg_we_o),
    .fwd_idx_i     (vreg_widx_o),
    .fwd_be_i      (vreg_wbe_o),
    .fwd_data_i    (vreg_wdata_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_lane_en_o (mem_lane_en_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .unsup_o       (unsup_o),
    .ld_go_o       (ld_go),
    .ld_sz_o       (ld_sz),
    .ld_elem_o     (ld_elem),
    .ld_vt_o       (ld_vt)
  );

  vsls_wb_stage u_wb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ld_go_i       (ld_go),
    .sz_i          (ld_sz),
    .elem_i        (ld_elem),
    .vt_i          (ld_vt),
    .mem_rdata_i   (mem_rdata_i),
    .vreg_we_o     (vreg_we_o),
    .vreg_widx_o   (vreg_widx_o),
    .vreg_wbe_o    (vreg_wbe_o),
    .vreg_wdata_o  (vreg_wdata_o)
  );
endmodule

// File: rtl/vsls_unit_chk.sv
module vsls_unit_chk
  import vsls_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_valid_i,
  input logic [31:0]       instr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [MAXB-1:0]   mem_lane_en_o,
  input logic              vreg_we_o,
  input logic [VBYTES-1:0] vreg_wbe_o,
  input logic              unsup_o
);
  p_store_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[31:26] == OPC_STORE && instr_i[15:11] < 5'd4)
      |=> (mem_req_o && mem_we_o));

  p_load_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[31:26] == OPC_LOAD && instr_i[15:11] < 5'd4)
      |=> (mem_req_o && !mem_we_o));

  p_wb_follows_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> vreg_we_o);

  p_wb_has_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vreg_we_o |-> $past(mem_req_o && !mem_we_o));

  p_unsup_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> !mem_req_o);

  p_unsup_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[31:26] == OPC_LOAD && instr_i[15:11] >= 5'd4) |=> unsup_o);

  p_load_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vreg_we_o |-> ($countones(vreg_wbe_o) >= 1 && $countones(vreg_wbe_o) <= MAXB));

  p_no_stray_wbe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vreg_we_o |-> (vreg_wbe_o == '0));

  p_store_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_lane_en_o == 8'h01 || mem_lane_en_o == 8'h03 ||
                                 mem_lane_en_o == 8'h0F || mem_lane_en_o == 8'hFF));

  p_idle_lanes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> (mem_lane_en_o == '0));

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!mem_req_o && !vreg_we_o && !unsup_o));
endmodule

bind vsls_unit vsls_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_lane_en_o (mem_lane_en_o),
  .vreg_we_o     (vreg_we_o),
  .vreg_wbe_o    (vreg_wbe_o),
  .unsup_o       (unsup_o)
);

// File: tb/sim_vsls_unit.sv
`timescale 1ns/1ps
module sim_vsls_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [4:0]   base_idx, vreg_ridx, vreg_widx;
  logic [31:0]  base_val;
  logic [127:0] vreg_rdata, vreg_wdata;
  logic         vreg_we, mem_req, mem_we, unsup;
  logic [15:0]  vreg_wbe;
  logic [7:0]   lane_en;
  logic [95:0]  mem_addr;
  logic [63:0]  mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  logic [31:0]  gpr [32];
  logic [127:0] vrf [32];
  logic [7:0]   mem [4096];
  logic [7:0]   ref_v [32][16];
  logic [7:0]   ref_m [4096];

  assign base_val   = gpr[base_idx];
  assign vreg_rdata = vrf[vreg_ridx];

  always @(posedge clk) begin
    if (vreg_we)
      for (int i = 0; i < 16; i++)
        if (vreg_wbe[i]) vrf[vreg_widx][127-8*i -: 8] <= vreg_wdata[127-8*i -: 8];
    if (mem_req)
      for (int k = 0; k < 8; k++)
        if (lane_en[k]) begin
          if (mem_we) mem[mem_addr[12*k +: 12]] <= mem_wdata[8*k +: 8];
          else        mem_rdata[8*k +: 8] <= mem[mem_addr[12*k +: 12]];
        end
  end

  vsls_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
    .base_idx_o(base_idx), .base_val_i(base_val),
    .vreg_ridx_o(vreg_ridx), .vreg_rdata_i(vreg_rdata),
    .vreg_we_o(vreg_we), .vreg_widx_o(vreg_widx), .vreg_wbe_o(vreg_wbe),
    .vreg_wdata_o(vreg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_lane_en_o(lane_en),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .unsup_o(unsup)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sequential byte-level model
  task automatic ref_exec(input bit st, input int sz, input int el, input logic [6:0] off,
                          input logic [31:0] base, input int vt);
    int size = 1 << sz;
    logic [31:0] soff = {{25{off[6]}}, off};
    logic [31:0] a = base + soff * size;
    for (int k = 0; k < size; k++) begin
      int ma = int'((a + k) & 32'hFFF);
      if (st) ref_m[ma] = ref_v[vt][(el + k) % 16];
      else if (el + k < 16) ref_v[vt][el + k] = ref_m[ma];
    end
  endtask

  task automatic cmp_state(input string req);
    int bad = 0;
    int ba = 0, be = 0;
    for (int r = 0; r < 32; r++)
      for (int i = 0; i < 16; i++)
        if (vrf[r][127-8*i -: 8] !== ref_v[r][i]) begin
          if (bad == 0) begin ba = vrf[r][127-8*i -: 8]; be = ref_v[r][i]; end
          bad++;
        end
    for (int m = 0; m < 4096; m++)
      if (mem[m] !== ref_m[m]) begin
        if (bad == 0) begin ba = mem[m]; be = ref_m[m]; end
        bad++;
      end
    check(bad == 0, req, ba, be);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rb,
                                     input logic [4:0] vt, input logic [4:0] sub,
                                     input logic [3:0] el, input logic [6:0] off);
    return {op, rb, vt, sub, el, off};
  endfunction

  typedef struct packed {
    logic       st;
    logic [1:0] sz;
    logic [3:0] el;
    logic [6:0] off;
    logic [11:0] base;
    logic [4:0] vt;
    logic [3:0] nb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, 4'd8,  7'h00, 12'h100, 5'd1, 4'd1},
    '{1'b0, 2'd1, 4'd4,  7'h03, 12'h200, 5'd2, 4'd2},
    '{1'b0, 2'd2, 4'd13, 7'h00, 12'h301, 5'd3, 4'd3},
    '{1'b0, 2'd3, 4'd0,  7'h7F, 12'h410, 5'd4, 4'd8},
    '{1'b0, 2'd3, 4'd10, 7'h02, 12'h003, 5'd5, 4'd6},
    '{1'b0, 2'd2, 4'd0,  7'h00, 12'hFFE, 5'd6, 4'd4},
    '{1'b1, 2'd0, 4'd8,  7'h05, 12'h500, 5'd1, 4'd1},
    '{1'b1, 2'd1, 4'd14, 7'h7E, 12'h600, 5'd2, 4'd2},
    '{1'b1, 2'd2, 4'd15, 7'h01, 12'h700, 5'd3, 4'd4},
    '{1'b1, 2'd3, 4'd12, 7'h00, 12'hFFD, 5'd4, 4'd8},
    '{1'b1, 2'd3, 4'd0,  7'h3F, 12'h800, 5'd7, 4'd8},
    '{1'b0, 2'd1, 4'd15, 7'h00, 12'h123, 5'd8, 4'd1}
  };

  initial begin : wdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int m = 0; m < 4096; m++) begin
      mem[m] = 8'((m * 37 + 11) & 255);
      ref_m[m] = mem[m];
    end
    for (int r = 0; r < 32; r++) begin
      gpr[r] = '0;
      for (int i = 0; i < 16; i++) begin
        ref_v[r][i] = 8'(((r * 16 + i) * 7 + 3) & 255);
        vrf[r][127-8*i -: 8] = ref_v[r][i];
      end
    end
    mem_rdata = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: quiet during reset
    check(!mem_req && !vreg_we && !unsup, "R10 reset outputs", {mem_req, vreg_we, unsup}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !vreg_we && !unsup, "R10 after reset", {mem_req, vreg_we, unsup}, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R8
    for (int n = 0; n < NV; n++) begin
      vec_t v = TBL[n];
      gpr[9] = {20'hABCDE, v.base};
      ref_exec(v.st, int'(v.sz), int'(v.el), v.off, gpr[9], int'(v.vt));
      valid = 1'b1;
      instr = mk(v.st ? 6'h3A : 6'h32, 5'd9, v.vt, {3'b0, v.sz}, v.el, v.off);
      @(negedge clk);
      valid = 1'b0;
      check(mem_req && (mem_we == v.st), "R8 request timing", {mem_req, mem_we}, {1'b1, v.st});
      if (v.st)
        check($countones(lane_en) == int'(v.nb), "R5 store byte count",
              $countones(lane_en), int'(v.nb));
      @(negedge clk);
      if (!v.st)
        check(vreg_we && $countones(vreg_wbe) == int'(v.nb), "R3 R4 load write window",
              $countones(vreg_wbe), int'(v.nb));
      else
        check(!vreg_we, "R8 store makes no write-back", vreg_we, 0);
      @(negedge clk);
      cmp_state("R1 R2 R6 state after table entry");
    end

    // R9: load then store of same register back to back
    gpr[9]  = 32'h0000_0040;
    gpr[10] = 32'h0000_0A00;
    ref_exec(1'b0, 3, 0, 7'h00, gpr[9], 10);
    ref_exec(1'b1, 3, 0, 7'h00, gpr[10], 10);
    valid = 1'b1;
    instr = mk(6'h32, 5'd9, 5'd10, 5'd3, 4'd0, 7'h00);
    @(negedge clk);
    instr = mk(6'h3A, 5'd10, 5'd10, 5'd3, 4'd0, 7'h00);
    @(negedge clk);
    valid = 1'b0;
    check(mem_req && mem_we && vreg_we, "R9 write-back and store overlap",
          {mem_req, mem_we, vreg_we}, 7);
    repeat (3) @(negedge clk);
    cmp_state("R9 store sees loaded bytes");

    // R7: unsupported size code
    valid = 1'b1;
    instr = mk(6'h32, 5'd9, 5'd11, 5'd5, 4'd0, 7'h00);
    @(negedge clk);
    valid = 1'b0;
    check(unsup && !mem_req, "R7 flag and no request", {unsup, mem_req}, 2);
    @(negedge clk);
    check(!unsup && !vreg_we, "R7 single-cycle flag", {unsup, vreg_we}, 0);
    @(negedge clk);
    cmp_state("R7 no state change");

    // R11: foreign opcode
    valid = 1'b1;
    instr = mk(6'h23, 5'd9, 5'd12, 5'd1, 4'd0, 7'h00);
    @(negedge clk);
    valid = 1'b0;
    check(!unsup && !mem_req, "R11 ignored opcode", {unsup, mem_req}, 0);
    repeat (2) @(negedge clk);
    cmp_state("R11 no state change");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule